// File: doc/BRIEF.md
# ARX Hash Compression Controller

This block runs the 32-bit-word ARX compression function over one or more consecutive 64-byte message blocks. It keeps the eight-word chaining value, a 64-bit byte counter and, for each block, the two finalization flag words. For every block it first advances the counter. It then builds a sixteen-word working matrix from the chaining value, the fixed initial-value words, the counter and the flags. Ten mixing rounds run over that matrix, and the result is folded back into the chaining value.

A host first loads a starting chaining value and counter through the load port. It then offers blocks through a valid/ready handshake. The first block of a run supplies the block count and the byte increment for that block. Every later block of the run advances the counter by 64. The chaining value and the counter are kept between runs, so a message can be hashed across several runs. Padding, parameter-block construction and output truncation are left to the surrounding logic.

Top module: `arx_compress_ctrl`

## Requirements
- R1: After reset `cv_o` and `cnt_o` are zero, `blk_ready_o` is 1 and `done_o` is 0.
- R2: While the controller is idle and no block is accepted in that cycle, `cv_load_i` copies `cv_i` into the chaining value and `cnt_i` into the counter, visible on the next cycle. Word k of either value sits in bits 32k+31:32k. The load is ignored while a block is being processed and while a multi-block run waits for its next block.
- R3: Byte j of a block is `blk_data_i[8j+7:8j]`. Message word k is built little-endian from bytes 4k..4k+3, with byte 4k in bits 7:0.
- R4: When a block is accepted, the 64-bit counter (low word in bits 31:0) grows by the increment, and the carry out of the low word goes into the high word. The first block of a run uses `inc_i`. The new value appears on `cnt_o` in the cycle after acceptance.
- R5: Every block after the first in a run advances the counter by exactly 64, whatever `inc_i` holds.
- R6: Each block uses a working matrix built as follows. Words 0-7 are the chaining value. Words 8-11 are the initial-value words 0-3. Words 12 and 13 are initial-value words 4 and 5, XORed with the low and high counter words after the increment. Words 14 and 15 are initial-value words 6 and 7, XORed with `f0_i` and `f1_i` as sampled at acceptance. Ten rounds of the standard message schedule then run, and chaining word i becomes h[i]^v[i]^v[i+8].
- R7: `blk_ready_o` is low for the 20 cycles of processing. The folded chaining value appears on `cv_o`, and `blk_ready_o` returns to 1, 20 cycles after the acceptance edge.
- R8: `nblk_i` is sampled with the first block of a run, and a count of 0 is treated as 1. `done_o` is a one-cycle pulse that comes with the fold of the last block. Between the blocks of a run, `done_o` stays low and `blk_ready_o` is high.
- R9: The chaining value and the counter keep their values between runs, and the next run continues from them.
- R10: A block offered while `blk_ready_o` is low is not taken. It changes neither the counter nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cv_load_i | input | 1 | Load chaining value and counter (idle only) |
| cv_i | input | 256 | Chaining value to load, word k in bits 32k+31:32k |
| cnt_i | input | 64 | Counter value to load |
| blk_valid_i | input | 1 | Message block offered |
| blk_ready_o | output | 1 | Controller can take a block |
| blk_data_i | input | 512 | Message block, byte j in bits 8j+7:8j |
| nblk_i | input | NB_W | Blocks in the run, sampled with the first block |
| inc_i | input | INC_W | Counter increment for the first block of a run |
| f0_i | input | 32 | First finalization flag word, sampled per block |
| f1_i | input | 32 | Second finalization flag word, sampled per block |
| cv_o | output | 256 | Current chaining value |
| cnt_o | output | 64 | Current byte counter |
| done_o | output | 1 | One-cycle pulse when a run's last block is folded |

## Verification
The hardest situations to reach from the ports are the pause between blocks of a run and the carry out of the low counter word. During the pause the controller is ready yet must refuse loads. The carry only happens after about four billion bytes of traffic. The stimulus uses the load port to preset the counter a few bytes below the low-word boundary and then runs three blocks across it. Multi-block runs pulse `cv_load_i` during the pause and during processing. They also hold a changed block on the handshake while the controller is busy. A single-block known-answer vector with a three-byte message pins down byte order and the flag seeding against published results.

// File: rtl/arx_compress_pkg.sv
`timescale 1ns/1ps
package arx_compress_pkg;
  localparam int WORD_W  = 32;
  localparam int CTR_W   = 64;
  localparam int SCHED_N = 10;

  typedef logic [WORD_W-1:0]        word_t;
  typedef logic [15:0][WORD_W-1:0]  mat_t;
  typedef logic [7:0][WORD_W-1:0]   cv_t;

  function automatic word_t iv_word(input logic [2:0] k);
    case (k)
      3'd0: return 32'h6A09E667;
      3'd1: return 32'hBB67AE85;
      3'd2: return 32'h3C6EF372;
      3'd3: return 32'hA54FF53A;
      3'd4: return 32'h510E527F;
      3'd5: return 32'h9B05688C;
      3'd6: return 32'h1F83D9AB;
      default: return 32'h5BE0CD19;
    endcase
  endfunction

  // Message schedule: nibble k of row r names the word used in slot k
  function automatic logic [63:0] sched_row(input logic [3:0] r);
    case (r)
      4'd0: return 64'hFEDCBA9876543210;
      4'd1: return 64'h357B20C16DF984AE;
      4'd2: return 64'h491763EADF250C8B;
      4'd3: return 64'h8F04A562EBCD1397;
      4'd4: return 64'hD386CB1EFA427509;
      4'd5: return 64'h91EF57D438B0A6C2;
      4'd6: return 64'hB8293670A4DEF15C;
      4'd7: return 64'hA2684F05931CE7BD;
      4'd8: return 64'h5A417D2C803B9EF6;
      default: return 64'h0DC3E9BF5167482A;
    endcase
  endfunction

  function automatic logic [3:0] sched_sel(input logic [3:0] r, input logic [3:0] k);
    logic [63:0] row;
    row = sched_row(r);
    return row[{k, 2'b00} +: 4];
  endfunction

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction
endpackage

// File: rtl/arx_mix_g.sv
`timescale 1ns/1ps
module arx_mix_g
  import arx_compress_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  input  word_t x_i,
  input  word_t y_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1;

  always_comb begin
    a1  = a_i + b_i + x_i;
    d1  = rotr(d_i ^ a1, 16);
    c1  = c_i + d1;
    b1  = rotr(b_i ^ c1, 12);
    a_o = a1 + b1 + y_i;
    d_o = rotr(d1 ^ a_o, 8);
    c_o = c1 + d_o;
    b_o = rotr(b1 ^ c_o, 7);
  end
endmodule

// File: rtl/arx_half_round.sv
`timescale 1ns/1ps
module arx_half_round
  import arx_compress_pkg::*;
(
  input  mat_t       v_i,
  input  mat_t       m_i,
  input  logic [3:0] row_i,
  input  logic       diag_i,
  output mat_t       v_o
);
  logic [3:0] ia [4];
  logic [3:0] ib [4];
  logic [3:0] ic [4];
  logic [3:0] id [4];
  logic [3:0] sx [4];
  logic [3:0] sy [4];
  word_t na [4];
  word_t nb [4];
  word_t nc [4];
  word_t nd [4];

  // Lane L takes a=L; diagonal pass shifts rows b,c,d by 1,2,3
  always_comb begin
    for (int l = 0; l < 4; l++) begin
      ia[l] = {2'b00, 2'(l)};
      ib[l] = {2'b01, 2'(l) + {1'b0, diag_i}};
      ic[l] = {2'b10, 2'(l) + {diag_i, 1'b0}};
      id[l] = {2'b11, 2'(l) + {diag_i, diag_i}};
      sx[l] = sched_sel(row_i, {diag_i, 2'(l), 1'b0});
      sy[l] = sched_sel(row_i, {diag_i, 2'(l), 1'b1});
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    arx_mix_g u_mix (
      .a_i(v_i[ia[g]]), .b_i(v_i[ib[g]]), .c_i(v_i[ic[g]]), .d_i(v_i[id[g]]),
      .x_i(m_i[sx[g]]), .y_i(m_i[sy[g]]),
      .a_o(na[g]), .b_o(nb[g]), .c_o(nc[g]), .d_o(nd[g])
    );
  end

  always_comb begin
    v_o = v_i;
    for (int l = 0; l < 4; l++) begin
      v_o[ia[l]] = na[l];
      v_o[ib[l]] = nb[l];
      v_o[ic[l]] = nc[l];
      v_o[id[l]] = nd[l];
    end
  end
endmodule

// File: rtl/arx_seed.sv
`timescale 1ns/1ps
module arx_seed
  import arx_compress_pkg::*;
(
  input  cv_t              h_i,
  input  logic [CTR_W-1:0] t_i,
  input  word_t            f0_i,
  input  word_t            f1_i,
  output mat_t             v_o
);
  for (genvar k = 0; k < 8; k++) begin : g_top
    assign v_o[k] = h_i[k];
  end
  for (genvar k = 0; k < 4; k++) begin : g_iv
    assign v_o[8+k] = iv_word(3'(k));
  end
  assign v_o[12] = iv_word(3'd4) ^ t_i[WORD_W-1:0];
  assign v_o[13] = iv_word(3'd5) ^ t_i[CTR_W-1:WORD_W];
  assign v_o[14] = iv_word(3'd6) ^ f0_i;
  assign v_o[15] = iv_word(3'd7) ^ f1_i;
endmodule

// File: rtl/arx_compress_ctrl.sv
`timescale 1ns/1ps
module arx_compress_ctrl
  import arx_compress_pkg::*;
#(
  parameter int NB_W       = 8,
  parameter int INC_W      = 7,
  parameter int NUM_ROUNDS = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cv_load_i,
  input  logic [8*WORD_W-1:0] cv_i,
  input  logic [CTR_W-1:0]   cnt_i,
  input  logic               blk_valid_i,
  output logic               blk_ready_o,
  input  logic [16*WORD_W-1:0] blk_data_i,
  input  logic [NB_W-1:0]    nblk_i,
  input  logic [INC_W-1:0]   inc_i,
  input  logic [WORD_W-1:0]  f0_i,
  input  logic [WORD_W-1:0]  f1_i,
  output logic [8*WORD_W-1:0] cv_o,
  output logic [CTR_W-1:0]   cnt_o,
  output logic               done_o
);
  localparam int RND_W = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1;
  localparam logic [RND_W-1:0] RND_LAST = RND_W'(NUM_ROUNDS - 1);
  localparam logic [CTR_W-1:0] LATER_INC = CTR_W'(64);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT} st_e;

  st_e              state_q;
  cv_t              h_q;
  logic [CTR_W-1:0] t_q;
  mat_t             v_q, m_q;
  logic [RND_W-1:0] rnd_q;
  logic [3:0]       row_q;
  logic             half_q;
  logic [NB_W-1:0]  rem_q;
  logic             done_q;

  logic             accept, first_blk, last_step, wait_blk;
  logic [CTR_W-1:0] t_next;
  mat_t             v_seed, v_nx;
  cv_t              cv_fold;

  assign blk_ready_o = (state_q != ST_RUN);
  assign accept      = blk_valid_i & blk_ready_o;
  assign first_blk   = (state_q == ST_IDLE);
  assign wait_blk    = (state_q == ST_WAIT);
  assign t_next      = t_q + (first_blk ? CTR_W'(inc_i) : LATER_INC);
  assign last_step   = half_q && (rnd_q == RND_LAST);

  arx_seed u_seed (
    .h_i(h_q), .t_i(t_next), .f0_i(f0_i), .f1_i(f1_i), .v_o(v_seed)
  );

  arx_half_round u_half (
    .v_i(v_q), .m_i(m_q), .row_i(row_q), .diag_i(half_q), .v_o(v_nx)
  );

  for (genvar k = 0; k < 8; k++) begin : g_fold
    assign cv_fold[k] = h_q[k] ^ v_nx[k] ^ v_nx[k+8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      h_q     <= '0;
      t_q     <= '0;
      v_q     <= '0;
      m_q     <= '0;
      rnd_q   <= '0;
      row_q   <= '0;
      half_q  <= 1'b0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_RUN) begin
        v_q    <= v_nx;
        half_q <= ~half_q;
        if (half_q) begin
          rnd_q <= rnd_q + 1'b1;
          row_q <= (row_q == 4'(SCHED_N - 1)) ? 4'd0 : row_q + 4'd1;
        end
        if (last_step) begin
          h_q   <= cv_fold;
          rem_q <= rem_q - 1'b1;
          if (rem_q == NB_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_WAIT;
          end
        end
      end else if (accept) begin
        v_q     <= v_seed;
        // Byte j sits at bits 8j+7:8j, so word k is already little-endian
        m_q     <= mat_t'(blk_data_i);
        t_q     <= t_next;
        rnd_q   <= '0;
        row_q   <= '0;
        half_q  <= 1'b0;
        state_q <= ST_RUN;
        if (first_blk) rem_q <= (nblk_i == '0) ? NB_W'(1) : nblk_i;
      end else if (cv_load_i && first_blk) begin
        h_q <= cv_t'(cv_i);
        t_q <= cnt_i;
      end
    end
  end

  assign cv_o   = h_q;
  assign cnt_o  = t_q;
  assign done_o = done_q;
endmodule

// File: rtl/arx_compress_chk.sv
`timescale 1ns/1ps
module arx_compress_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         blk_valid_i,
  input logic         blk_ready_o,
  input logic         cv_load_i,
  input logic         done_o,
  input logic [255:0] cv_o,
  input logic [63:0]  cnt_o,
  input logic         wait_blk
);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (blk_ready_o && !wait_blk));

  // R7
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_i && blk_ready_o) |=> !blk_ready_o);

  // R7
  cv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_ready_o |-> $stable(cv_o));

  // R10
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blk_ready_o && $past(!blk_ready_o)) |-> $stable(cnt_o));

  // R5
  later_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_i && blk_ready_o && wait_blk) |=> (cnt_o == $past(cnt_o) + 64'd64));

  // R2
  load_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_blk && cv_load_i && !blk_valid_i) |=> ($stable(cv_o) && $stable(cnt_o)));
endmodule

bind arx_compress_ctrl arx_compress_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .blk_valid_i(blk_valid_i),
  .blk_ready_o(blk_ready_o), .cv_load_i(cv_load_i), .done_o(done_o),
  .cv_o(cv_o), .cnt_o(cnt_o), .wait_blk(wait_blk)
);

// File: tb/tb_arx_compress_ctrl.sv
`timescale 1ns/1ps
module tb_arx_compress_ctrl;
  localparam int NB_W  = 8;
  localparam int INC_W = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cv_load_i = 1'b0;
  logic [255:0]      cv_i = '0;
  logic [63:0]       cnt_i = '0;
  logic              blk_valid_i = 1'b0;
  logic              blk_ready_o;
  logic [511:0]      blk_data_i = '0;
  logic [NB_W-1:0]   nblk_i = '0;
  logic [INC_W-1:0]  inc_i = '0;
  logic [31:0]       f0_i = '0;
  logic [31:0]       f1_i = '0;
  logic [255:0]      cv_o;
  logic [63:0]       cnt_o;
  logic              done_o;

  always #5 clk_i = ~clk_i;

  arx_compress_ctrl #(.NB_W(NB_W), .INC_W(INC_W), .NUM_ROUNDS(10)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cv_load_i(cv_load_i), .cv_i(cv_i),
    .cnt_i(cnt_i), .blk_valid_i(blk_valid_i), .blk_ready_o(blk_ready_o),
    .blk_data_i(blk_data_i), .nblk_i(nblk_i), .inc_i(inc_i), .f0_i(f0_i),
    .f1_i(f1_i), .cv_o(cv_o), .cnt_o(cnt_o), .done_o(done_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0]  mh [8];
  logic [63:0]  mt;
  logic [31:0]  vv [16];
  logic [31:0]  mw [16];
  logic [511:0] tb_blk;

  function automatic logic [31:0] ivw(input int k);
    case (k)
      0: return 32'h6A09E667; 1: return 32'hBB67AE85;
      2: return 32'h3C6EF372; 3: return 32'hA54FF53A;
      4: return 32'h510E527F; 5: return 32'h9B05688C;
      6: return 32'h1F83D9AB; default: return 32'h5BE0CD19;
    endcase
  endfunction

  function automatic int sg(input int r, input int k);
    logic [63:0] row;
    case (r)
      0: row = 64'hFEDCBA9876543210; 1: row = 64'h357B20C16DF984AE;
      2: row = 64'h491763EADF250C8B; 3: row = 64'h8F04A562EBCD1397;
      4: row = 64'hD386CB1EFA427509; 5: row = 64'h91EF57D438B0A6C2;
      6: row = 64'hB8293670A4DEF15C; 7: row = 64'hA2684F05931CE7BD;
      8: row = 64'h5A417D2C803B9EF6; default: row = 64'h0DC3E9BF5167482A;
    endcase
    return int'(row[4*k +: 4]);
  endfunction

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  task automatic gref(input int a, input int b, input int c, input int d,
                      input logic [31:0] x, input logic [31:0] y);
    vv[a] = vv[a] + vv[b] + x; vv[d] = rr(vv[d] ^ vv[a], 16);
    vv[c] = vv[c] + vv[d];     vv[b] = rr(vv[b] ^ vv[c], 12);
    vv[a] = vv[a] + vv[b] + y; vv[d] = rr(vv[d] ^ vv[a], 8);
    vv[c] = vv[c] + vv[d];     vv[b] = rr(vv[b] ^ vv[c], 7);
  endtask

  task automatic ref_compress(input logic [31:0] f0, input logic [31:0] f1);
    for (int k = 0; k < 16; k++)
      mw[k] = {tb_blk[8*(4*k+3) +: 8], tb_blk[8*(4*k+2) +: 8],
               tb_blk[8*(4*k+1) +: 8], tb_blk[8*(4*k) +: 8]};
    for (int i = 0; i < 8; i++) begin
      vv[i] = mh[i];
      vv[8+i] = ivw(i);
    end
    vv[12] ^= mt[31:0]; vv[13] ^= mt[63:32]; vv[14] ^= f0; vv[15] ^= f1;
    for (int r = 0; r < 10; r++) begin
      for (int c = 0; c < 4; c++) gref(c, c+4, c+8, c+12, mw[sg(r, 2*c)], mw[sg(r, 2*c+1)]);
      gref(0, 5, 10, 15, mw[sg(r, 8)],  mw[sg(r, 9)]);
      gref(1, 6, 11, 12, mw[sg(r, 10)], mw[sg(r, 11)]);
      gref(2, 7, 8, 13,  mw[sg(r, 12)], mw[sg(r, 13)]);
      gref(3, 4, 9, 14,  mw[sg(r, 14)], mw[sg(r, 15)]);
    end
    for (int i = 0; i < 8; i++) mh[i] = mh[i] ^ vv[i] ^ vv[i+8];
  endtask

  function automatic logic [255:0] mh_flat();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = mh[i];
    return r;
  endfunction

  task automatic fill_blk(input int seed, input bit kat);
    for (int k = 0; k < 64; k++)
      tb_blk[8*k +: 8] = 8'(seed * 29 + k * 13 + (k >> 2) * seed + 7);
    if (kat) begin
      tb_blk = '0;
      tb_blk[7:0] = 8'h61; tb_blk[15:8] = 8'h62; tb_blk[23:16] = 8'h63;
    end
  endtask

  // ---------------- stimulus tasks ----------------
  task automatic do_load(input logic [255:0] cv, input logic [63:0] cnt);
    @(negedge clk_i);
    cv_i = cv; cnt_i = cnt; cv_load_i = 1'b1;
    @(negedge clk_i);
    cv_load_i = 1'b0;
    for (int i = 0; i < 8; i++) mh[i] = cv[32*i +: 32];
    mt = cnt;
    chk(cv_o == cv, "R2 load cv", cv_o, cv);
    chk(cnt_o == cnt, "R2 load cnt", 256'(cnt_o), 256'(cnt));
  endtask

  task automatic run_blocks(input int nblk_req, input logic [INC_W-1:0] inc, input int seed,
                            input logic [31:0] f0_last, input bit hold_busy,
                            input bit poke_load, input bit kat);
    int nb;
    int lat;
    logic [31:0] f0, f1;
    nb = (nblk_req == 0) ? 1 : nblk_req;
    for (int b = 0; b < nb; b++) begin
      bit last;
      last = (b == nb - 1);
      f0 = last ? f0_last : 32'h0;
      f1 = (last && !kat) ? (f0_last ^ 32'h1357_9BDF) : 32'h0;
      @(negedge clk_i);
      lat = 0;
      while (!blk_ready_o && lat < 100) begin @(negedge clk_i); lat++; end
      fill_blk(seed + b, kat);
      blk_data_i = tb_blk; f0_i = f0; f1_i = f1;
      nblk_i = NB_W'(nblk_req); inc_i = inc; blk_valid_i = 1'b1;
      mt = mt + ((b == 0) ? 64'(inc) : 64'd64);
      @(negedge clk_i);
      chk(blk_ready_o == 1'b0, "R7 ready low after accept", 256'(blk_ready_o), 256'd0);
      chk(cnt_o == mt, (b == 0) ? "R4 first increment" : "R5 later increment of 64",
          256'(cnt_o), 256'(mt));
      if (hold_busy) begin
        blk_data_i = ~tb_blk; f0_i = ~f0; nblk_i = 8'd9;
      end else begin
        blk_valid_i = 1'b0;
      end
      lat = 0;
      do begin
        if (lat == 10) blk_valid_i = 1'b0;
        if (lat == 5 && poke_load) begin cv_i = ~mh_flat(); cnt_i = ~mt; cv_load_i = 1'b1; end
        if (lat == 6) cv_load_i = 1'b0;
        @(negedge clk_i);
        lat++;
      end while (!blk_ready_o && lat < 100);
      chk(lat == 20, "R7 fold latency", 256'(lat), 256'd20);
      ref_compress(f0, f1);
      chk(cv_o == mh_flat(), "R6 chaining value after fold", cv_o, mh_flat());
      chk(done_o == last, "R8 done only on last block", 256'(done_o), 256'(last));
      if (hold_busy) chk(cnt_o == mt, "R10 busy offer not taken", 256'(cnt_o), 256'(mt));
      if (last) begin
        @(negedge clk_i);
        chk(done_o == 1'b0, "R8 done is one cycle", 256'(done_o), 256'd0);
      end else if (poke_load) begin
        cv_i = ~mh_flat(); cnt_i = 64'h1234; cv_load_i = 1'b1;
        @(negedge clk_i);
        cv_load_i = 1'b0;
        chk(cv_o == mh_flat() && cnt_o == mt, "R2 load ignored between blocks", cv_o, mh_flat());
      end
    end
  endtask

  // ---------------- main ----------------
  initial begin
    logic [255:0] kat_iv, kat_exp, keep_cv;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cv_o == '0, "R1 reset cv", cv_o, '0);
    chk(cnt_o == '0, "R1 reset cnt", 256'(cnt_o), '0);
    chk(blk_ready_o == 1'b1, "R1 reset ready", 256'(blk_ready_o), 256'd1);
    chk(done_o == 1'b0, "R1 reset done", 256'(done_o), '0);

    // Known answer: three-byte message, digest length 32, unkeyed
    for (int i = 0; i < 8; i++) kat_iv[32*i +: 32] = ivw(i);
    kat_iv[31:0] = kat_iv[31:0] ^ 32'h0101_0020;
    kat_exp = {32'h82596786, 32'h4C9B994D, 32'h293AD69E, 32'h208B4537,
               32'h2F45EB4E, 32'hA32BA7E1, 32'hE2147C32, 32'h8C5E8C50};
    do_load(kat_iv, 64'd0);
    run_blocks(1, 7'd3, 0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1);
    chk(cv_o == kat_exp, "R3 little-endian words known answer", cv_o, kat_exp);

    // Persistence across runs
    keep_cv = cv_o;
    repeat (7) @(negedge clk_i);
    chk(cv_o == keep_cv && cnt_o == 64'd3, "R9 state kept while idle", cv_o, keep_cv);
    run_blocks(2, 7'd64, 11, 32'h0, 1'b0, 1'b0, 1'b0);
    chk(cnt_o == 64'd131, "R9 counter continues from previous run", 256'(cnt_o), 256'd131);

    // Sweep over block counts and flag values
    for (int nbk = 0; nbk <= 4; nbk++) begin
      for (int fl = 0; fl < 2; fl++) begin
        run_blocks(nbk, 7'(nbk * 13 + fl * 50 + 1), 100 + nbk * 7 + fl,
                   fl ? 32'hFFFF_FFFF : 32'h0, nbk == 1, nbk == 2, 1'b0);
      end
    end

    // Carry from low counter word into high word
    do_load(~kat_exp, 64'h0000_0000_FFFF_FFF0);
    run_blocks(3, 7'd64, 500, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0);
    chk(cnt_o == 64'h0000_0001_000000B0, "R4 carry into high word", 256'(cnt_o),
        256'(64'h0000_0001_000000B0));

    // Maximum first increment with carry
    do_load(kat_exp, 64'hFFFF_FFFE_FFFF_FFFF);
    run_blocks(1, 7'd127, 900, 32'h0, 1'b1, 1'b0, 1'b0);
    chk(cnt_o == 64'hFFFF_FFFF_0000_007E, "R4 wide increment carry", 256'(cnt_o),
        256'(64'hFFFF_FFFF_0000_007E));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule